// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block is the interrupt register bank of one memory-to-memory DMA channel. The datapath reports events as one-cycle pulses: transfer done, bus errors, descriptor read errors and descriptor completions. The bank latches each pulse into a sticky status register. Software clears status bits by writing ones back to the status register.

Masking is controlled through two write-only registers. One clears mask bits and the other sets them. The mask itself can only be read. Two 8-bit completion counters, one for the source side and one for the destination side, count completion pulses. Each counter saturates, reports overflow through a status bit, and clears when it is read.

The bank drives one registered, level-sensitive interrupt output and the channel enable bit. It is accessed through a plain 32-bit port: address, write enable, write data, read enable and read data. Read data is registered.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset, status reads 0, mask reads 0x7FF (all sources masked), both counters read 0, control reads 0, and `irq_o` and `chan_en_o` are 0.
- R2: A pulse on `evt_i[b]` sets status bit b. The bit positions are: 10 transfer done, 9 write-data bus error, 8 read-data bus error, 7 destination-descriptor read error, 6 source-descriptor read error, 5 destination count overflow, 4 source count overflow, 3 byte count overflow, 2 destination descriptor done, 0 invalid register access. Bit 1 has no source and always reads 0.
- R3: A write to offset 0x100 clears every status bit written as one and leaves the other bits unchanged. An event in the same cycle as the clear of its bit leaves that bit set.
- R4: Writing ones to offset 0x108 unmasks those sources, and writing ones to offset 0x10C masks them. The mask at offset 0x104 reads 1 for a masked source and ignores writes. Offsets 0x108 and 0x10C read 0.
- R5: `irq_o` is 1 exactly one cycle after a cycle in which any status bit is set and unmasked; otherwise it is 0.
- R6: Pulses on `src_done_i` and `dst_done_i` increment the counters at 0x190 and 0x194. A read returns the current count and clears the counter. A read that coincides with an increment leaves the count at 1.
- R7: An increment of a counter that holds 255 leaves it at 255. It sets status bit 4 for the source counter or bit 5 for the destination counter.
- R8: A read or write to any offset other than 0x100, 0x104, 0x108, 0x10C, 0x190, 0x194 or 0x200 sets status bit 0, and such a read returns 0. Writes to read-only registers at listed offsets are ignored and do not count as invalid.
- R9: Bit 0 of a write to offset 0x200 sets `chan_en_o`. Offset 0x200 reads the enable in bit 0 and 0 in every other bit.
- R10: `rdata_o` shows the register value from before the read cycle, one cycle after `rd_en_i`, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 11 | One-cycle event pulses, one per status bit |
| src_done_i | input | 1 | Source completion pulse |
| dst_done_i | input | 1 | Destination completion pulse |
| irq_o | output | 1 | Level interrupt |
| chan_en_o | output | 1 | Channel enable |

## Verification
The embedded assertions check the following on every cycle:
- Events take priority over write-one-to-clear.
- Mask bits follow enable and disable writes.
- The interrupt follows the unmasked pending set one cycle later.
- Counters clear, reload to one and saturate correctly.
- Invalid accesses flag status bit 0 and read 0.
- The control write reaches the enable output.

Only the bench scenarios can show end-to-end properties:
- Register read values returned through the port.
- That read-only registers ignore writes.
- That the unused status bit stays 0.
- That overflow status follows exactly 256 increments.
- The random interleaving of events, clears and counter reads against the reference model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned STAT_W = 11;

  localparam int OFS_STAT = 'h100;
  localparam int OFS_MASK = 'h104;
  localparam int OFS_IEN  = 'h108;
  localparam int OFS_IDIS = 'h10C;
  localparam int OFS_SCNT = 'h190;
  localparam int OFS_DCNT = 'h194;
  localparam int OFS_CTRL = 'h200;

  localparam int unsigned BIT_INVAL   = 0;
  localparam int unsigned BIT_SRC_OVF = 4;
  localparam int unsigned BIT_DST_OVF = 5;

  // bit 1 has no source
  localparam logic [STAT_W-1:0] STAT_IMPL = 11'h7FD;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_MASK, SEL_IEN, SEL_IDIS, SEL_SCNT, SEL_DCNT, SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output reg_sel_e          sel_o,
  output logic              inval_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFS_STAT)) sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_MASK)) sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_IEN))  sel_o = SEL_IEN;
    else if (addr_i == ADDR_W'(OFS_IDIS)) sel_o = SEL_IDIS;
    else if (addr_i == ADDR_W'(OFS_SCNT)) sel_o = SEL_SCNT;
    else if (addr_i == ADDR_W'(OFS_DCNT)) sel_o = SEL_DCNT;
    else if (addr_i == ADDR_W'(OFS_CTRL)) sel_o = SEL_CTRL;
  end

  assign inval_o = (wr_en_i || rd_en_i) && (sel_o == SEL_NONE);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned          STAT_W = 11,
  parameter logic [STAT_W-1:0]    IMPL   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic [STAT_W-1:0] ien_i,
  input  logic [STAT_W-1:0] idis_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] status_q, mask_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      // new events win over a coincident clear
      status_q <= ((status_q & ~clr_i) | set_i) & IMPL;
      mask_q   <= (mask_q & ~ien_i) | idis_i;
      irq_q    <= |(status_q & ~mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & IMPL) |=> ((status_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
  assert_unmask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |ien_i && !(|idis_i) |=> ((mask_q & $past(ien_i)) == '0));
  assert_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |idis_i |=> ((mask_q & $past(idis_i)) == $past(idis_i)));
  assert_irq_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(status_q & ~mask_q) |=> irq_o);
  assert_irq_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_q & ~mask_q)) |=> !irq_o);
endmodule

// File: rtl/dma_irq_counter.sv
module dma_irq_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= CNT_W'(inc_i);
    else if (inc_i && !at_max)  cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = inc_i && !clr_i && at_max;
  assign cnt_o = cnt_q;

  assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !inc_i |=> cnt_q == '0);
  assert_clr_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && inc_i |=> cnt_q == CNT_W'(1));
  assert_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              src_done_i,
  input  logic              dst_done_i,
  output logic              irq_o,
  output logic              chan_en_o
);
  localparam int unsigned N_CNT = 2;

  reg_sel_e          sel;
  logic              inval;
  logic [STAT_W-1:0] wbits, stat_set, stat_clr, ien, idis, status, mask;
  logic [N_CNT-1:0]  cnt_inc, cnt_clr, cnt_ovf;
  logic [CNT_W-1:0]  cnt_val [N_CNT];
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              en_q;
  logic              wdata_unused;

  assign wbits        = wdata_i[STAT_W-1:0];
  assign wdata_unused = ^wdata_i[DATA_W-1:STAT_W];

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .sel_o   (sel),
    .inval_o (inval)
  );

  assign cnt_inc = {dst_done_i, src_done_i};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    localparam reg_sel_e SEL_G = (g == 0) ? SEL_SCNT : SEL_DCNT;
    assign cnt_clr[g] = rd_en_i && (sel == SEL_G);
    dma_irq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc[g]),
      .clr_i  (cnt_clr[g]),
      .cnt_o  (cnt_val[g]),
      .ovf_o  (cnt_ovf[g])
    );
  end

  always_comb begin
    stat_set = evt_i;
    stat_set[BIT_SRC_OVF] = evt_i[BIT_SRC_OVF] | cnt_ovf[0];
    stat_set[BIT_DST_OVF] = evt_i[BIT_DST_OVF] | cnt_ovf[1];
    stat_set[BIT_INVAL]   = evt_i[BIT_INVAL]   | inval;
  end

  assign stat_clr = (wr_en_i && sel == SEL_STAT) ? wbits : '0;
  assign ien      = (wr_en_i && sel == SEL_IEN)  ? wbits : '0;
  assign idis     = (wr_en_i && sel == SEL_IDIS) ? wbits : '0;

  dma_irq_status #(.STAT_W(STAT_W), .IMPL(STAT_IMPL)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (stat_set),
    .clr_i    (stat_clr),
    .ien_i    (ien),
    .idis_i   (idis),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_STAT: rd_val = DATA_W'(status);
      SEL_MASK: rd_val = DATA_W'(mask);
      SEL_SCNT: rd_val = DATA_W'(cnt_val[0]);
      SEL_DCNT: rd_val = DATA_W'(cnt_val[1]);
      SEL_CTRL: rd_val = DATA_W'(en_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      en_q    <= 1'b0;
    end else begin
      if (rd_en_i)                      rdata_q <= rd_val;
      if (wr_en_i && sel == SEL_CTRL)   en_q    <= wdata_i[0];
    end
  end

  assign rdata_o   = rdata_q;
  assign chan_en_o = en_q;

  assert_inval_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval |=> status[BIT_INVAL]);
  assert_inval_rd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && inval |=> rdata_o == '0);
  assert_ctrl_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sel == SEL_CTRL |=> chan_en_o == $past(wdata_i[0]));
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/dma_irq_bank_tb.sv
module dma_irq_bank_tb_top;
  localparam time CLK_PERIOD = 20ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] evt = '0;
  logic        sdone = 1'b0, ddone = 1'b0;
  logic        irq, chan_en;

  int errors = 0;
  int checks = 0;

  // reference model
  logic [10:0] m_stat = '0;
  logic [10:0] m_mask = 11'h7FF;
  logic [7:0]  m_sc = '0, m_dc = '0;
  logic        m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .evt_i(evt), .src_done_i(sdone),
    .dst_done_i(ddone), .irq_o(irq), .chan_en_o(chan_en)
  );

  function automatic bit is_valid(input logic [11:0] a);
    return a == 12'h100 || a == 12'h104 || a == 12'h108 || a == 12'h10C ||
           a == 12'h190 || a == 12'h194 || a == 12'h200;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h100: return {21'b0, m_stat};
      12'h104: return {21'b0, m_mask};
      12'h190: return {24'b0, m_sc};
      12'h194: return {24'b0, m_dc};
      12'h200: return {31'b0, m_en};
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] wd, input logic [10:0] ev,
                      input bit si, input bit di, input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq, inv, s_clr, d_clr, s_ovf, d_ovf;
    logic [10:0] set, clr;
    exp_rd  = exp_read(a);
    exp_irq = |(m_stat & ~m_mask);
    inv     = (wr || rd) && !is_valid(a);
    s_clr   = rd && a == 12'h190;
    d_clr   = rd && a == 12'h194;
    s_ovf   = si && !s_clr && m_sc == 8'hFF;
    d_ovf   = di && !d_clr && m_dc == 8'hFF;
    set     = ev | (11'(s_ovf) << 4) | (11'(d_ovf) << 5) | 11'(inv);
    clr     = (wr && a == 12'h100) ? wd[10:0] : '0;
    addr = a; wr_en = wr; rd_en = rd; wdata = wd; evt = ev; sdone = si; ddone = di;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0; sdone = 1'b0; ddone = 1'b0;
    m_stat = ((m_stat & ~clr) | set) & 11'h7FD;
    if (wr && a == 12'h108) m_mask = m_mask & ~wd[10:0];
    if (wr && a == 12'h10C) m_mask = m_mask | wd[10:0];
    if (wr && a == 12'h200) m_en = wd[0];
    if (s_clr) m_sc = 8'(si); else if (si && m_sc != 8'hFF) m_sc = m_sc + 1;
    if (d_clr) m_dc = 8'(di); else if (di && m_dc != 8'hFF) m_dc = m_dc + 1;
    if (rd) check(rdata === exp_rd, tag, $sformatf("read %h", a), rdata, exp_rd);
    check(irq === exp_irq, "R5", "irq_o", 32'(irq), 32'(exp_irq));
    check(chan_en === m_en, "R9", "chan_en_o", 32'(chan_en), 32'(m_en));
  endtask

  task automatic rd_reg(input logic [11:0] a, input string tag);
    step(0, 1, a, '0, '0, 0, 0, tag);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, '0, 0, 0, tag);
  endtask

  logic [31:0] held;
  logic [11:0] ra;
  logic        done = 1'b0;

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq === 1'b0 && chan_en === 1'b0, "R1", "outputs", {irq, chan_en}, 0);
    rd_reg(12'h100, "R1"); rd_reg(12'h104, "R1"); rd_reg(12'h190, "R1");
    rd_reg(12'h194, "R1"); rd_reg(12'h200, "R1");

    // R2 every event bit, including unused bit 1
    for (int b = 0; b < 11; b++) begin
      step(0, 0, 12'h0, '0, 11'(1) << b, 0, 0, "R2");
      rd_reg(12'h100, "R2");
      wr_reg(12'h100, 32'h7FF, "R2");
    end
    rd_reg(12'h100, "R2");

    // R4 mask control
    wr_reg(12'h108, 32'h7FF, "R4"); rd_reg(12'h104, "R4");
    wr_reg(12'h104, 32'h123, "R4"); rd_reg(12'h104, "R4");
    wr_reg(12'h10C, 32'h00F, "R4"); rd_reg(12'h104, "R4");
    rd_reg(12'h108, "R4"); rd_reg(12'h10C, "R4");

    // R5 interrupt follows unmasked status
    step(0, 0, 12'h0, '0, 11'h400, 0, 0, "R5");
    step(0, 0, 12'h0, '0, '0, 0, 0, "R5");
    check(irq === 1'b1, "R5", "irq after done event", 32'(irq), 1);
    step(0, 0, 12'h0, '0, 11'h008, 0, 0, "R5");  // masked source

    // R3 clear only ones, event beats clear
    wr_reg(12'h100, 32'h008, "R3"); rd_reg(12'h100, "R3");
    step(1, 0, 12'h100, 32'h400, 11'h400, 0, 0, "R3");
    rd_reg(12'h100, "R3");
    wr_reg(12'h100, 32'h7FF, "R3"); rd_reg(12'h100, "R3");

    // R6 counting, clear on read, read with increment
    repeat (5) step(0, 0, 12'h0, '0, '0, 1, 0, "R6");
    rd_reg(12'h190, "R6"); rd_reg(12'h190, "R6");
    repeat (3) step(0, 0, 12'h0, '0, '0, 0, 1, "R6");
    step(0, 1, 12'h194, '0, '0, 0, 1, "R6");
    rd_reg(12'h194, "R6");

    // R7 saturation and overflow bits
    repeat (256) step(0, 0, 12'h0, '0, '0, 1, 1, "R7");
    rd_reg(12'h100, "R7"); rd_reg(12'h190, "R7"); rd_reg(12'h194, "R7");
    wr_reg(12'h100, 32'h7FF, "R7");

    // R8 invalid accesses
    rd_reg(12'h118, "R8"); rd_reg(12'h100, "R8");
    wr_reg(12'h100, 32'h001, "R8");
    wr_reg(12'h0FC, 32'hFFFF_FFFF, "R8"); rd_reg(12'h100, "R8");
    wr_reg(12'h190, 32'h55, "R8"); wr_reg(12'h100, 32'h001, "R8"); rd_reg(12'h100, "R8");

    // R9 channel enable
    wr_reg(12'h200, 32'hFFFF_FFFF, "R9"); rd_reg(12'h200, "R9");
    wr_reg(12'h200, 32'h0, "R9"); rd_reg(12'h200, "R9");

    // R10 read data held
    rd_reg(12'h104, "R10");
    held = rdata;
    wr_reg(12'h10C, 32'h7FF, "R10");
    step(0, 0, 12'h0, '0, 11'h7FF, 1, 1, "R10");
    check(rdata === held, "R10", "rdata hold", rdata, held);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 8)
        0: ra = 12'h100; 1: ra = 12'h104; 2: ra = 12'h108; 3: ra = 12'h10C;
        4: ra = 12'h190; 5: ra = 12'h194; 6: ra = 12'h200;
        default: ra = 12'(($urandom % 1024) & 12'hFFC);
      endcase
      step(($urandom % 3) == 0, ($urandom % 2) == 0, ra, $urandom,
           11'($urandom & $urandom & $urandom), ($urandom % 4) == 0,
           ($urandom % 4) == 0, "R10");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule